// File: doc/BRIEF.md
# Duty-Ratio Engine Clock Throttle

This block slows the average rate of an engine clock without touching the clock tree. It runs on the fast clock and produces a clock enable. The enable alternates between two regimes. In the full-rate regime it is high on every cycle. In the divided regime it pulses once every 2^k cycles. An 8-bit pulse-width modulator with a 256-cycle period chooses the regime, so the average rate can be set anywhere between the divided rate and the full rate instead of only in coarse power-of-two steps. Using a clock enable rather than a switching clock mux means no glitches or runt clock pulses can occur.

Four kinds of request can throttle the engine: a software force, a power-cap alarm, a set of temperature thresholds and engine idle. Each request carries its own divisor code and duty value, except that all temperature thresholds share one duty value. A fixed priority picks one setting, and that setting is reported on the outputs. A regime or divisor change waits until the current divided period has ended, so every divided interval is complete.

Top module: `rate_throttle`

## Requirements
- R1: While reset is asserted and directly after it is released, with no request active, `clkEn` is 1, `activeCode` is 0 and `activeDuty` is 255.
- R2: With no request asserted, the active setting is code 0 and duty 255, and `clkEn` is high on every cycle.
- R3: A divisor code k in 0..4 means a divide ratio of 2^k, and codes 5, 6 and 7 behave as, and are reported as, code 4. The active setting outputs follow a request change one clock edge later.
- R4: With an active duty of 0 the enable never uses the full-rate regime: it gives exactly 256/2^k pulses in any 256 consecutive cycles, evenly spaced 2^k cycles apart.
- R5: With an active duty of 255 the enable is high on every cycle, whatever the divisor.
- R6: For a duty d in 1..254, each 256-cycle modulator period holds d full-rate cycles and 256-d divided cycles. When 2^k divides 256-d, any 256 consecutive cycles hold exactly d + (256-d)/2^k enable cycles.
- R7: When several requests are active, the software force wins over the power cap, the power cap over any temperature threshold, and a temperature threshold over idle.
- R8: Among the temperature thresholds (`tempHit` bit i, code in `tempCode` bits [3i+2:3i]), the highest-indexed asserted bit supplies the divisor code. The duty is always the shared `tempDuty`.
- R9: A change of divisor or of regime takes effect only at the end of the divided period in progress. After a pulse at divisor 2^k, the next pulse comes exactly 2^k cycles later even if the request changes in between. In divided mode with k ≥ 1, a pulse is never followed by a high enable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast engine clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Engine idle request (lowest priority) |
| tempHit | input | NUM_TEMP | One bit per reached temperature threshold |
| powerCap | input | 1 | Power usage at its cap |
| swForce | input | 1 | Software force (highest priority) |
| idleCode | input | 3 | Divisor code for idle |
| idleDuty | input | 8 | Duty value for idle |
| tempCode | input | 3*NUM_TEMP | Divisor code for each temperature threshold |
| tempDuty | input | 8 | Duty value shared by all thresholds |
| capCode | input | 3 | Divisor code for the power cap |
| capDuty | input | 8 | Duty value for the power cap |
| swCode | input | 3 | Divisor code for the software force |
| swDuty | input | 8 | Duty value for the software force |
| clkEn | output | 1 | Clock enable for the engine |
| activeCode | output | 3 | Divisor code in force (clamped) |
| activeDuty | output | 8 | Duty value in force |

## Verification
The hardest situation to reach is a request change that lands partway through a long divided period. If the timing is off, the change either lands on a boundary or is never seen. The bench first settles into divisor 16 with duty 0. It then waits until it sees an enable pulse at the ports and changes the request three cycles later. Then it measures the distance to the next pulse, and to the one after it. It does this for both a divisor change and a switch to the full-rate regime. For the steady-state ratios, the bench chooses duty and divisor pairs where the divided stretch is a whole number of divided periods. That makes the enable count over any 256-cycle window an exact closed-form number.

// File: rtl/rate_throttle_pkg.sv
package rate_throttle_pkg;

  // width of a divisor code (codes 0..7, ratio 2^code)
  localparam int CODE_W = 3;

  // control-to-datapath strobes, refreshed every cycle
  typedef struct packed {
    logic              wantFull;  // modulator asks for full-rate regime
    logic [CODE_W-1:0] divCode;   // clamped divisor code in force
  } rateStrobe_t;

endpackage

// File: rtl/rate_throttle_ctrl.sv
module rate_throttle_ctrl
  import rate_throttle_pkg::*;
#(
  parameter int NUM_TEMP = 3,
  parameter int DUTY_W   = 8,
  parameter int MAX_CODE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       idleReq,
  input  logic [NUM_TEMP-1:0]        tempHit,
  input  logic                       powerCap,
  input  logic                       swForce,
  input  logic [CODE_W-1:0]          idleCode,
  input  logic [DUTY_W-1:0]          idleDuty,
  input  logic [NUM_TEMP*CODE_W-1:0] tempCode,
  input  logic [DUTY_W-1:0]          tempDuty,
  input  logic [CODE_W-1:0]          capCode,
  input  logic [DUTY_W-1:0]          capDuty,
  input  logic [CODE_W-1:0]          swCode,
  input  logic [DUTY_W-1:0]          swDuty,
  output logic [CODE_W-1:0]          activeCode,
  output logic [DUTY_W-1:0]          activeDuty,
  output rateStrobe_t                strb
);

  localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(MAX_CODE);

  function automatic logic [CODE_W-1:0] clampCode(input logic [CODE_W-1:0] c);
    return (c > CODE_LIM) ? CODE_LIM : c;
  endfunction

  // clamped codes per source
  logic [CODE_W-1:0] idleCodeC, capCodeC, swCodeC;
  logic [CODE_W-1:0] tempCodeC [NUM_TEMP];

  assign idleCodeC = clampCode(idleCode);
  assign capCodeC  = clampCode(capCode);
  assign swCodeC   = clampCode(swCode);

  generate
    for (genvar g = 0; g < NUM_TEMP; g++) begin : gTempClamp
      assign tempCodeC[g] = clampCode(tempCode[g*CODE_W +: CODE_W]);
    end
  endgenerate

  logic tempAny, anyReq;
  assign tempAny = |tempHit;
  assign anyReq  = swForce | powerCap | tempAny | idleReq;

  // fixed-priority selection
  logic [CODE_W-1:0] selCode;
  logic [DUTY_W-1:0] selDuty;

  always_comb begin
    selCode = '0;
    selDuty = DUTY_MAX;
    if (swForce) begin
      selCode = swCodeC;
      selDuty = swDuty;
    end else if (powerCap) begin
      selCode = capCodeC;
      selDuty = capDuty;
    end else if (tempAny) begin
      selDuty = tempDuty;
      for (int i = 0; i < NUM_TEMP; i++) begin
        if (tempHit[i]) selCode = tempCodeC[i];
      end
    end else if (idleReq) begin
      selCode = idleCodeC;
      selDuty = idleDuty;
    end
  end

  // active setting register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= '0;
      activeDuty <= DUTY_MAX;
    end else begin
      activeCode <= selCode;
      activeDuty <= selDuty;
    end
  end

  // free-running modulator counter, one period = 2^DUTY_W cycles
  logic [DUTY_W-1:0] pwmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + DUTY_W'(1);
  end

  always_comb begin
    strb.wantFull = (activeDuty == DUTY_MAX) || (pwmCnt < activeDuty);
    strb.divCode  = activeCode;
  end

  AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    $past(!anyReq) |-> (activeCode == '0 && activeDuty == DUTY_MAX)); // R2

  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    $past(swForce) |-> (activeCode == $past(swCodeC) && activeDuty == $past(swDuty))); // R7

  AST_TEMP_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(tempAny && !swForce && !powerCap) |-> activeDuty == $past(tempDuty)); // R8

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    activeCode <= CODE_LIM); // R3

endmodule

// File: rtl/rate_throttle_dp.sv
module rate_throttle_dp
  import rate_throttle_pkg::*;
#(
  parameter int MAX_CODE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  rateStrobe_t strb,
  output logic        clkEn
);

  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic              curFull;
  logic [CODE_W-1:0] curCode;
  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W:0]    oneHot;
  logic [CNT_W-1:0]  divMask;
  logic              divEdge, boundary;

  assign oneHot   = (CNT_W+1)'(1) << curCode;
  assign divMask  = CNT_W'(oneHot - (CNT_W+1)'(1));
  assign divEdge  = (divCnt == divMask);
  assign boundary = curFull | divEdge;
  assign clkEn    = curFull | divEdge;

  // regime and divisor are latched only at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curFull <= 1'b1;
      curCode <= '0;
      divCnt  <= '0;
    end else if (boundary) begin
      curFull <= strb.wantFull;
      curCode <= strb.divCode;
      divCnt  <= '0;
    end else begin
      divCnt  <= divCnt + CNT_W'(1);
    end
  end

  AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(clkEn && strb.wantFull) |-> clkEn); // R5

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(clkEn && !strb.wantFull && strb.divCode != '0) |-> !clkEn); // R9

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rstN)
    $past(!clkEn) |-> $stable(curCode)); // R9

endmodule

// File: rtl/rate_throttle.sv
module rate_throttle
  import rate_throttle_pkg::*;
#(
  parameter int NUM_TEMP = 3,
  parameter int DUTY_W   = 8,
  parameter int MAX_CODE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       idleReq,
  input  logic [NUM_TEMP-1:0]        tempHit,
  input  logic                       powerCap,
  input  logic                       swForce,
  input  logic [2:0]                 idleCode,
  input  logic [DUTY_W-1:0]          idleDuty,
  input  logic [NUM_TEMP*3-1:0]      tempCode,
  input  logic [DUTY_W-1:0]          tempDuty,
  input  logic [2:0]                 capCode,
  input  logic [DUTY_W-1:0]          capDuty,
  input  logic [2:0]                 swCode,
  input  logic [DUTY_W-1:0]          swDuty,
  output logic                       clkEn,
  output logic [2:0]                 activeCode,
  output logic [DUTY_W-1:0]          activeDuty
);

  rateStrobe_t strb;

  rate_throttle_ctrl #(
    .NUM_TEMP (NUM_TEMP),
    .DUTY_W   (DUTY_W),
    .MAX_CODE (MAX_CODE)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .idleReq    (idleReq),
    .tempHit    (tempHit),
    .powerCap   (powerCap),
    .swForce    (swForce),
    .idleCode   (idleCode),
    .idleDuty   (idleDuty),
    .tempCode   (tempCode),
    .tempDuty   (tempDuty),
    .capCode    (capCode),
    .capDuty    (capDuty),
    .swCode     (swCode),
    .swDuty     (swDuty),
    .activeCode (activeCode),
    .activeDuty (activeDuty),
    .strb       (strb)
  );

  rate_throttle_dp #(
    .MAX_CODE (MAX_CODE)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .clkEn (clkEn)
  );

endmodule

// File: tb/sim_rate_throttle.sv
`timescale 1ns/1ps
module sim_rate_throttle;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idleReq = 0, powerCap = 0, swForce = 0;
  logic [2:0] tempHit = '0;
  logic [2:0] idleCode = 0, capCode = 0, swCode = 0;
  logic [8:0] tempCode = '0;
  logic [7:0] idleDuty = 0, tempDuty = 0, capDuty = 0, swDuty = 0;
  logic       clkEn;
  logic [2:0] activeCode;
  logic [7:0] activeDuty;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  rate_throttle u0 (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .tempHit(tempHit),
    .powerCap(powerCap), .swForce(swForce), .idleCode(idleCode),
    .idleDuty(idleDuty), .tempCode(tempCode), .tempDuty(tempDuty),
    .capCode(capCode), .capDuty(capDuty), .swCode(swCode), .swDuty(swDuty),
    .clkEn(clkEn), .activeCode(activeCode), .activeDuty(activeDuty)
  );

  // {code, duty, expected enables per 256 cycles, expected reported code}
  localparam int NVEC = 12;
  localparam int VEC [NVEC][4] = '{
    '{0,   0, 256, 0},
    '{1,   0, 128, 1},
    '{2,   0,  64, 2},
    '{4,   0,  16, 4},
    '{3, 255, 256, 3},
    '{4, 255, 256, 4},
    '{1, 128, 192, 1},
    '{2,  64, 112, 2},
    '{4,  96, 106, 4},
    '{3, 200, 207, 3},
    '{7,   0,  16, 4},
    '{5, 128, 136, 4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic countEn(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (clkEn) c++;
    end
  endtask

  // waits for a pulse, changes the software setting 3 cycles later,
  // returns distances to the next two pulses
  task automatic gapAfterChange(input logic [2:0] newCode, input logic [7:0] newDuty,
                                output int d1, output int d2);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!clkEn && guard < 100);
    d1 = 0;
    do begin
      @(negedge clk);
      d1++;
      if (d1 == 3) begin
        swCode = newCode;
        swDuty = newDuty;
      end
    end while (!clkEn && d1 < 100);
    d2 = 0;
    do begin
      @(negedge clk);
      d2++;
    end while (!clkEn && d2 < 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int c, d1, d2;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(clkEn == 1'b1, "R1 en in reset", int'(clkEn), 1);
    chk(activeCode == 0 && activeDuty == 255, "R1 setting in reset", int'(activeDuty), 255);
    rstN = 1'b1;
    @(negedge clk);
    chk(clkEn == 1'b1 && activeCode == 0, "R1 en after reset", int'(clkEn), 1);

    // R2 no request, config set but idle
    idleCode = 3; idleDuty = 10; capCode = 2; capDuty = 30;
    swCode = 1; swDuty = 40; tempDuty = 20;
    tempCode = {3'd4, 3'd3, 3'd2};
    repeat (300) @(negedge clk);
    chk(activeCode == 0 && activeDuty == 255, "R2 default setting", int'(activeDuty), 255);
    countEn(256, c);
    chk(c == 256, "R2 enable count", c, 256);

    // R7 / R8 / R3 priority and latency
    idleReq = 1; tempHit = 3'b111; powerCap = 1; swForce = 1;
    @(negedge clk);
    chk(activeCode == 1 && activeDuty == 40, "R7 sw wins (R3 one-edge latency)", int'(activeDuty), 40);
    swForce = 0;
    @(negedge clk);
    chk(activeCode == 2 && activeDuty == 30, "R7 cap over temp", int'(activeDuty), 30);
    powerCap = 0;
    @(negedge clk);
    chk(activeCode == 4 && activeDuty == 20, "R8 highest threshold", int'(activeCode), 4);
    tempHit = 3'b011;
    @(negedge clk);
    chk(activeCode == 3 && activeDuty == 20, "R8 threshold 1", int'(activeCode), 3);
    tempHit = 3'b001;
    @(negedge clk);
    chk(activeCode == 2 && activeDuty == 20, "R8 threshold 0 shared duty", int'(activeCode), 2);
    tempHit = 3'b000;
    @(negedge clk);
    chk(activeCode == 3 && activeDuty == 10, "R7 idle lowest", int'(activeCode), 3);
    idleReq = 0;
    @(negedge clk);
    chk(activeCode == 0 && activeDuty == 255, "R2 release", int'(activeDuty), 255);

    // table walk: R3 R4 R5 R6
    swForce = 1;
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      swCode = 3'(VEC[v][0]);
      swDuty = 8'(VEC[v][1]);
      repeat (600) @(negedge clk);
      chk(activeCode == 3'(VEC[v][3]), "R3 reported code", int'(activeCode), VEC[v][3]);
      countEn(256, c);
      if (VEC[v][1] == 0)        tag = "R4 divided-only count";
      else if (VEC[v][1] == 255) tag = "R5 full-only count";
      else                       tag = "R6 mixed count";
      chk(c == VEC[v][2], tag, c, VEC[v][2]);
    end

    // R9 divisor change mid-period
    swCode = 4; swDuty = 0;
    repeat (600) @(negedge clk);
    gapAfterChange(3'd1, 8'd0, d1, d2);
    chk(d1 == 16, "R9 old period completes", d1, 16);
    chk(d2 == 2, "R9 new divisor after boundary", d2, 2);

    // R9 regime change mid-period
    swCode = 4; swDuty = 0;
    repeat (600) @(negedge clk);
    gapAfterChange(3'd4, 8'd255, d1, d2);
    chk(d1 == 16, "R9 full waits for boundary", d1, 16);
    chk(d2 == 1, "R9 full after boundary", d2, 1);
    countEn(20, c);
    chk(c == 20, "R9 R5 stays full", c, 20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule